// File: doc/BRIEF.md
# Weighted Transmit/Receive Bus Arbiter

This block shares one host bus master port between a transmit DMA channel and a receive DMA channel. Each channel raises a request line. The arbiter answers with a grant for one channel, and that grant stays in place until the channel pulses `done` to close its bus transaction. The arbiter makes a new decision only while no grant is active. A decision made on an idle cycle shows up as a grant on the following cycle.

Two policies are available, chosen by `cfg_rx_first`. In weighted round-robin mode (`cfg_rx_first` = 0), the 2-bit `cfg_ratio` field lets transmit win up to 1, 2, 3 or 4 contested decisions in a row before receive is served once. In fixed mode (`cfg_rx_first` = 1), receive always wins a contested decision. A channel that requests alone is always granted. Both configuration inputs are read only at decision points, so changing them during a grant cannot disturb that grant. The synchronous `soft_rst` input clears the arbiter state in the same way as `rst`.

Top module: `wdma_arbiter`

## Requirements
- R1: While `rst` or `soft_rst` is high, both grants are low. After reset the transmit streak count is zero.
- R2: `tx_gnt` and `rx_gnt` are never high in the same cycle.
- R3: A grant stays high, unchanged, until a cycle in which `done` is high. The grant is low in the cycle after that. A `done` pulse while no grant is active has no effect.
- R4: Decisions happen only on cycles with no active grant. A request seen on such a cycle produces the grant one cycle later. After `done`, at least one idle cycle passes before the next grant.
- R5: If only one channel requests at a decision point, that channel is granted, whatever the mode or ratio.
- R6: When `cfg_rx_first` = 0 and both channels request continuously, the grant order repeats K transmit grants followed by one receive grant. K is `cfg_ratio`+1: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 3, 2'b11 gives 4.
- R7: When `cfg_rx_first` = 1, a decision with both channels requesting goes to receive.
- R8: `cfg_ratio` and `cfg_rx_first` are used only at decision points. Changing them while a grant is active leaves that grant unchanged, and the new values apply at the next decision.
- R9: A cycle with `soft_rst` high drops any active grant and clears the transmit streak. The next contested decision then starts a fresh K-transmit run.
- R10: Transmit grants won without competition also count toward the streak. The count saturates at 4, so a waiting receive request wins the next contested decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous software reset of the arbiter state |
| cfg_ratio | input | 2 | Transmit:receive weight, K = value+1 |
| cfg_rx_first | input | 1 | 0 = weighted round-robin, 1 = receive has strict priority |
| tx_req | input | 1 | Transmit channel requests the bus |
| rx_req | input | 1 | Receive channel requests the bus |
| done | input | 1 | Pulse from the granted channel that ends its transaction |
| tx_gnt | output | 1 | Bus granted to transmit |
| rx_gnt | output | 1 | Bus granted to receive |

## Verification
The embedded assertions check, on every cycle: grant exclusivity, that a grant holds until `done`, that grants are clean after a software reset, that a new grant always follows a request on an idle cycle, and the lone-requester and fixed-priority decisions. Only the bench scenarios can show the weighted run lengths for every ratio setting, that a configuration change made mid-grant applies only at the next decision, and that the streak restarts after a software reset. For those, the bench records grant sequences and compares them with a behavioural model on every clock.

// File: rtl/wdma_arb_pkg.sv
package wdma_arb_pkg;

    // width of the weight field
    localparam int RATIO_W = 2;
    // largest run of transmit grants
    localparam int RUN_MAX = 1 << RATIO_W;
    // width of the streak counter, which holds 0..RUN_MAX
    localparam int CNT_W   = $clog2(RUN_MAX + 1);

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_TX   = 2'd1,
        OWN_RX   = 2'd2
    } owner_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               rx_first;
    } arb_cfg_t;

    // transmit grants allowed before receive is served
    function automatic logic [CNT_W-1:0] run_limit(input logic [RATIO_W-1:0] r);
        return CNT_W'(r) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/wdma_arb_pick.sv
module wdma_arb_pick
    import wdma_arb_pkg::*;
(
    input  arb_cfg_t            cfg,
    input  logic [CNT_W-1:0]    streak,
    input  logic                tx_req,
    input  logic                rx_req,
    output owner_e              pick
);
    logic tx_spent;

    assign tx_spent = (streak >= run_limit(cfg.ratio));

    always_comb begin
        pick = OWN_NONE;
        if (tx_req && rx_req) begin
            pick = (cfg.rx_first || tx_spent) ? OWN_RX : OWN_TX;
        end else if (tx_req) begin
            pick = OWN_TX;
        end else if (rx_req) begin
            pick = OWN_RX;
        end
    end
endmodule

// File: rtl/wdma_arb_streak.sv
module wdma_arb_streak
    import wdma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (clr) begin
            count <= '0;
        end else if (inc && (count < CNT_W'(RUN_MAX))) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdma_arbiter.sv
module wdma_arbiter
    import wdma_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_rx_first,
    input  logic               tx_req,
    input  logic               rx_req,
    input  logic               done,
    output logic               tx_gnt,
    output logic               rx_gnt
);
    owner_e           owner_q;
    owner_e           pick;
    arb_cfg_t         cfg_now;
    logic [CNT_W-1:0] streak;
    logic             wipe;
    logic             idle;
    logic             str_clr;
    logic             str_inc;

    assign wipe    = rst || soft_rst;
    assign idle    = (owner_q == OWN_NONE);
    assign cfg_now = '{ratio: cfg_ratio, rx_first: cfg_rx_first};

    wdma_arb_pick u_pick (
        .cfg    (cfg_now),
        .streak (streak),
        .tx_req (tx_req),
        .rx_req (rx_req),
        .pick   (pick)
    );

    assign str_clr = wipe || (idle && pick == OWN_RX);
    assign str_inc = idle && pick == OWN_TX;

    wdma_arb_streak u_streak (
        .clk   (clk),
        .clr   (str_clr),
        .inc   (str_inc),
        .count (streak)
    );

    always_ff @(posedge clk) begin
        if (wipe) begin
            owner_q <= OWN_NONE;
        end else if (!idle) begin
            if (done) owner_q <= OWN_NONE;
        end else begin
            owner_q <= pick;
        end
    end

    assign tx_gnt = (owner_q == OWN_TX) && !wipe;
    assign rx_gnt = (owner_q == OWN_RX) && !wipe;

    // R2
    gnt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_gnt, rx_gnt}));

    // R1
    soft_clean_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!tx_gnt && !rx_gnt) || soft_rst);

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_gnt && !done) |=> (tx_gnt || soft_rst));

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_gnt && !done) |=> (rx_gnt || soft_rst));

    // R4
    tx_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_gnt) |-> $past(tx_req) && !$past(rx_gnt));

    // R4
    rx_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_gnt) |-> $past(rx_req) && !$past(tx_gnt));

    // R5
    lone_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_gnt && !rx_gnt && !soft_rst && tx_req && !rx_req) |=> (tx_gnt || soft_rst));

    // R7
    rx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_gnt && !rx_gnt && !soft_rst && rx_req && cfg_rx_first) |=> (rx_gnt || soft_rst));
endmodule

// File: tb/tb_wdma_arbiter.sv
module tb_wdma_arbiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic [1:0] cfg_ratio = 2'd0;
    logic       cfg_rx_first = 1'b0;
    logic       tx_req = 1'b0;
    logic       rx_req = 1'b0;
    logic       done = 1'b0;
    logic       tx_gnt;
    logic       rx_gnt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model: 0 none, 1 tx, 2 rx
    int m_own = 0;
    int m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdma_arbiter dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cfg_ratio(cfg_ratio), .cfg_rx_first(cfg_rx_first),
        .tx_req(tx_req), .rx_req(rx_req), .done(done),
        .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model advances on every edge
    always @(posedge clk) begin
        if (rst || soft_rst) begin
            m_own = 0; m_run = 0;
        end else if (m_own != 0) begin
            if (done) m_own = 0;
        end else if (tx_req && rx_req) begin
            if (cfg_rx_first || m_run >= int'(cfg_ratio) + 1) begin
                m_own = 2; m_run = 0;
            end else begin
                m_own = 1; if (m_run < 4) m_run++;
            end
        end else if (tx_req) begin
            m_own = 1; if (m_run < 4) m_run++;
        end else if (rx_req) begin
            m_own = 2; m_run = 0;
        end
    end

    // per-cycle comparison against the model (R2, R3, R4)
    always @(negedge clk) begin
        int ex_t, ex_r;
        ex_t = (m_own == 1 && !rst && !soft_rst) ? 1 : 0;
        ex_r = (m_own == 2 && !rst && !soft_rst) ? 1 : 0;
        check("R4 tx_gnt model", int'(tx_gnt), ex_t);
        check("R4 rx_gnt model", int'(rx_gnt), ex_r);
        check("R2 exclusive", int'(tx_gnt && rx_gnt), 0);
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic take_grant(output int who);
        who = 0;
        for (int k = 0; k < 12 && who == 0; k++) begin
            @(negedge clk);
            if (tx_gnt) who = 1; else if (rx_gnt) who = 2;
        end
        @(posedge clk); #1 done = 1'b1;
        @(posedge clk); #1 done = 1'b0;
    endtask

    task automatic pulse_soft();
        @(posedge clk); #1 soft_rst = 1'b1;
        @(posedge clk); #1 soft_rst = 1'b0;
    endtask

    initial begin
        int who;
        // R1 reset state
        step(1);
        @(negedge clk);
        check("R1 tx low in reset", int'(tx_gnt), 0);
        check("R1 rx low in reset", int'(rx_gnt), 0);
        @(posedge clk); #1 rst = 1'b0;
        step(2);

        // R3: done while idle ignored, then hold
        done = 1'b1; step(1); done = 1'b0;
        tx_req = 1'b1;
        step(2);
        @(negedge clk); check("R3 tx granted", int'(tx_gnt), 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); check("R3 held without done", int'(tx_gnt), 1);
        end
        @(posedge clk); #1 done = 1'b1;
        @(posedge clk); #1 done = 1'b0; tx_req = 1'b0;
        @(negedge clk); check("R3 dropped after done", int'(tx_gnt), 0);
        step(2);

        // R6 each ratio
        for (int r = 0; r < 4; r++) begin
            cfg_ratio = 2'(r); cfg_rx_first = 1'b0;
            pulse_soft();
            tx_req = 1'b1; rx_req = 1'b1;
            for (int i = 0; i < 2 * (r + 2); i++) begin
                take_grant(who);
                check($sformatf("R6 ratio %0d grant %0d", r, i), who,
                      ((i % (r + 2)) == r + 1) ? 2 : 1);
            end
            tx_req = 1'b0; rx_req = 1'b0;
            step(2);
        end

        // R7 fixed mode
        cfg_rx_first = 1'b1; cfg_ratio = 2'd3;
        tx_req = 1'b1; rx_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            take_grant(who); check("R7 rx wins", who, 2);
        end
        // R5 lone tx in fixed mode
        rx_req = 1'b0;
        take_grant(who); check("R5 lone tx", who, 1);
        tx_req = 1'b0; step(1);
        // R5 lone rx in round-robin with fresh streak
        cfg_rx_first = 1'b0; pulse_soft();
        rx_req = 1'b1;
        take_grant(who); check("R5 lone rx", who, 2);
        rx_req = 1'b0; step(2);

        // R10 uncontested tx grants count toward streak
        cfg_ratio = 2'd1; pulse_soft();
        tx_req = 1'b1;
        take_grant(who); take_grant(who);
        rx_req = 1'b1;
        take_grant(who); check("R10 streak counted lone tx", who, 2);
        tx_req = 1'b0; rx_req = 1'b0; step(2);

        // R8 config change mid-grant
        cfg_ratio = 2'd3; cfg_rx_first = 1'b0; pulse_soft();
        tx_req = 1'b1; rx_req = 1'b1;
        step(2);
        @(negedge clk); check("R8 first grant tx", int'(tx_gnt), 1);
        @(posedge clk); #1 cfg_rx_first = 1'b1; cfg_ratio = 2'd0;
        step(3);
        @(negedge clk); check("R8 tx kept after cfg change", int'(tx_gnt), 1);
        @(negedge clk); check("R8 rx not granted mid-grant", int'(rx_gnt), 0);
        @(posedge clk); #1 done = 1'b1;
        @(posedge clk); #1 done = 1'b0;
        take_grant(who); check("R8 new cfg at next decision", who, 2);
        cfg_rx_first = 1'b0; cfg_ratio = 2'd3;

        // R9 soft reset during grant, streak restarts
        take_grant(who); take_grant(who);
        step(1);
        @(negedge clk); check("R9 grant before soft", int'(tx_gnt), 1);
        @(posedge clk); #1 soft_rst = 1'b1;
        @(negedge clk); check("R1 no grant while soft", int'(tx_gnt | rx_gnt), 0);
        @(posedge clk); #1 soft_rst = 1'b0;
        tx_req = 1'b0; rx_req = 1'b0;
        @(negedge clk); check("R9 grant cleared", int'(tx_gnt | rx_gnt), 0);
        tx_req = 1'b1; rx_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            take_grant(who);
            check($sformatf("R9 fresh run grant %0d", i), who, (i == 4) ? 2 : 1);
        end
        tx_req = 1'b0; rx_req = 1'b0;
        step(3);
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule